// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Bank

This block holds a small set of 64-bit performance counters for a processor core: a free-running cycle counter, a retired-instruction counter and a parameterised number of programmable event counters. A counter advances only when its event occurs and every gating condition holds. The conditions are a debug-active flag, a per-counter inhibit bit, a per-counter mask bit for the programmable counters, a non-zero event selector, and a per-privilege-mode disable.

The mode disable is worked out combinationally from the privilege mode presented in the current cycle and three disable bits, one each for machine, supervisor and user mode. A change of mode therefore gates the counters in the same cycle. An event in the cycle that enters a disabled mode is not counted, and an event in the cycle that leaves one is not lost. A one-cycle registered copy of the mode disable is used only to keep the counter clock enable high across a transition.

Each counter can be preset through a synchronous write port. A programmable counter that wraps sets a sticky overflow flag. The flags, together with per-counter interrupt enables, drive a single interrupt request.

Top module: `evt_ctr_bank`

## Requirements
- R1: Privilege mode encoding is 2'b11 machine, 2'b01 supervisor and 2'b00 user. The mode disable equals the disable bit of the current mode. The reserved code 2'b10 is always treated as disabled.
- R2: The mode disable gates counting in the same cycle the new mode is presented. A transition into a disabled mode adds no count, and a transition out of one loses no count.
- R3: The cycle counter (write slot 0) adds one in every cycle in which debug is inactive, the mode disable is low and inhibit bit 0 is clear.
- R4: The retired-instruction counter (write slot 2) adds one when ret_i is high, debug is inactive, the mode disable is low and inhibit bit 2 is clear.
- R5: Programmable counter k (write slot k+3) adds one when evt_i[k] is high, debug is inactive, the mode disable is low, mask_i[k] is clear, inhibit bit k+3 is clear and its selector field sel_i[k*SEL_W +: SEL_W] is non-zero.
- R6: A write loads wr_data_i into the counter of slot wr_idx_i on the next clock edge and takes priority over an increment in that cycle. A write also clears that counter's overflow flag. Writes to slot 1 or to slots at or above N_PROG+3 change no counter.
- R7: A programmable counter that increments from all ones to zero sets a sticky overflow flag. irq_o is high while any counter k has both its flag and irq_en_i[k] set.
- R8: cnt_en_o is high exactly when debug is inactive and the mode disable is low.
- R9: clk_en_o is high when any of the following holds: a counter's gating conditions (all but its event pulse) hold, a write is requested, or the mode disable differs from its value in the previous cycle.
- R10: After reset every counter reads zero, every overflow flag is clear and the previous mode disable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Current privilege mode |
| dis_m_i | input | 1 | Disable counting in machine mode |
| dis_s_i | input | 1 | Disable counting in supervisor mode |
| dis_u_i | input | 1 | Disable counting in user mode |
| dbg_i | input | 1 | Debug mode active |
| inh_i | input | N_PROG+3 | Per-slot inhibit bits (slot 1 unused) |
| mask_i | input | N_PROG | Per programmable counter mask |
| sel_i | input | N_PROG*SEL_W | Event selectors, one field per programmable counter |
| ret_i | input | 1 | Instruction retired this cycle |
| evt_i | input | N_PROG | Event pulses for the programmable counters |
| irq_en_i | input | N_PROG | Overflow interrupt enables |
| wr_en_i | input | 1 | Counter preset request |
| wr_idx_i | input | $clog2(N_PROG+3) | Slot to preset |
| wr_data_i | input | CNT_W | Preset value |
| cyc_cnt_o | output | CNT_W | Cycle counter |
| ret_cnt_o | output | CNT_W | Retired-instruction counter |
| prog_cnt_o | output | N_PROG*CNT_W | Programmable counters, counter k at bits k*CNT_W |
| cnt_en_o | output | 1 | Global count enable |
| clk_en_o | output | 1 | Clock enable for the counter logic |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions check on every cycle that debug mode and a low global enable freeze all counters, and that an enabled cycle counter steps by exactly one. They also check that presets land, that a change in the global enable keeps the clock enable high, and that an interrupt request never appears without an enable. What only the bench's scenarios can show is the exact accounting across privilege changes: with events every cycle and modes toggling, the count must equal the events seen in enabled modes. The scenarios also cover the reserved mode code, the wrap and overflow sequence, and write priority and ignored slots, all against a bench model.

// File: rtl/evb_pkg.sv
package evb_pkg;
    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    localparam int SLOT_CYC   = 0;
    localparam int SLOT_RET   = 2;
    localparam int SLOT_PROG0 = 3;
endpackage

// File: rtl/evb_mode_gate.sv
module evb_mode_gate
    import evb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       dis_m_i,
    input  logic       dis_s_i,
    input  logic       dis_u_i,
    output logic       dis_now_o,
    output logic       dis_flip_o
);
    typedef struct packed {
        logic dis;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     dis_now;

    always_comb begin
        case (priv_e'(mode_i))
            PRIV_MACH:  dis_now = dis_m_i;
            PRIV_SUPER: dis_now = dis_s_i;
            PRIV_USER:  dis_now = dis_u_i;
            default:    dis_now = 1'b1;
        endcase
        st_d     = st_q;
        st_d.dis = dis_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dis_now_o  = dis_now;
    assign dis_flip_o = dis_now ^ st_q.dis;
endmodule

// File: rtl/evb_ctr_slot.sv
module evb_ctr_slot #(
    parameter int CNT_W     = 64,
    parameter bit TRACK_OVF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cnt = wdata_i;
            st_d.ovf = 1'b0;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (&st_q.cnt) st_d.ovf = 1'b1;
        end
        if (!TRACK_OVF) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evb_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int N_PROG = 4,
    parameter int SEL_W  = 8,
    localparam int NSLOT  = N_PROG + 3,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_i,
    input  logic                    dis_m_i,
    input  logic                    dis_s_i,
    input  logic                    dis_u_i,
    input  logic                    dbg_i,
    input  logic [NSLOT-1:0]        inh_i,
    input  logic [N_PROG-1:0]       mask_i,
    input  logic [N_PROG*SEL_W-1:0] sel_i,
    input  logic                    ret_i,
    input  logic [N_PROG-1:0]       evt_i,
    input  logic [N_PROG-1:0]       irq_en_i,
    input  logic                    wr_en_i,
    input  logic [SLOT_W-1:0]       wr_idx_i,
    input  logic [CNT_W-1:0]        wr_data_i,
    output logic [CNT_W-1:0]        cyc_cnt_o,
    output logic [CNT_W-1:0]        ret_cnt_o,
    output logic [N_PROG*CNT_W-1:0] prog_cnt_o,
    output logic                    cnt_en_o,
    output logic                    clk_en_o,
    output logic                    irq_o
);
    logic              dis_now, dis_flip, base_en;
    logic              cyc_arm, ret_arm;
    logic [N_PROG-1:0] prog_arm, prog_inc, prog_wr, prog_ovf;
    logic              unused_inh, unused_cyc_ovf, unused_ret_ovf;

    evb_mode_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .dis_m_i    (dis_m_i),
        .dis_s_i    (dis_s_i),
        .dis_u_i    (dis_u_i),
        .dis_now_o  (dis_now),
        .dis_flip_o (dis_flip)
    );

    assign base_en    = !dbg_i && !dis_now;
    assign cyc_arm    = base_en && !inh_i[SLOT_CYC];
    assign ret_arm    = base_en && !inh_i[SLOT_RET];
    assign unused_inh = inh_i[1];

    evb_ctr_slot #(.CNT_W(CNT_W), .TRACK_OVF(1'b0)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (cyc_arm),
        .wr_i    (wr_en_i && wr_idx_i == SLOT_W'(SLOT_CYC)),
        .wdata_i (wr_data_i),
        .cnt_o   (cyc_cnt_o),
        .ovf_o   (unused_cyc_ovf)
    );

    evb_ctr_slot #(.CNT_W(CNT_W), .TRACK_OVF(1'b0)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (ret_arm && ret_i),
        .wr_i    (wr_en_i && wr_idx_i == SLOT_W'(SLOT_RET)),
        .wdata_i (wr_data_i),
        .cnt_o   (ret_cnt_o),
        .ovf_o   (unused_ret_ovf)
    );

    for (genvar k = 0; k < N_PROG; k++) begin : g_prog
        assign prog_arm[k] = base_en && !mask_i[k] && !inh_i[SLOT_PROG0+k]
                             && (|sel_i[k*SEL_W +: SEL_W]);
        assign prog_inc[k] = prog_arm[k] && evt_i[k];
        assign prog_wr[k]  = wr_en_i && (wr_idx_i == SLOT_W'(SLOT_PROG0 + k));

        evb_ctr_slot #(.CNT_W(CNT_W), .TRACK_OVF(1'b1)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (prog_inc[k]),
            .wr_i    (prog_wr[k]),
            .wdata_i (wr_data_i),
            .cnt_o   (prog_cnt_o[k*CNT_W +: CNT_W]),
            .ovf_o   (prog_ovf[k])
        );
    end

    assign cnt_en_o = base_en;
    assign irq_o    = |(prog_ovf & irq_en_i);
    assign clk_en_o = cyc_arm || ret_arm || (|prog_arm) || wr_en_i || dis_flip;
endmodule

// File: rtl/evb_chk.sv
module evb_chk #(
    parameter int CNT_W  = 64,
    parameter int N_PROG = 4,
    parameter int NSLOT  = N_PROG + 3,
    parameter int SLOT_W = $clog2(N_PROG + 3)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dbg_i,
    input logic [NSLOT-1:0]        inh_i,
    input logic [N_PROG-1:0]       irq_en_i,
    input logic                    wr_en_i,
    input logic [SLOT_W-1:0]       wr_idx_i,
    input logic [CNT_W-1:0]        wr_data_i,
    input logic [CNT_W-1:0]        cyc_cnt_o,
    input logic [CNT_W-1:0]        ret_cnt_o,
    input logic [N_PROG*CNT_W-1:0] prog_cnt_o,
    input logic                    cnt_en_o,
    input logic                    clk_en_o,
    input logic                    irq_o
);
    // R8
    dbg_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_i |-> !cnt_en_o);

    // R3
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_o && !inh_i[0] && !wr_en_i) |=> cyc_cnt_o == $past(cyc_cnt_o) + CNT_W'(1));

    // R2
    frozen_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_o && !wr_en_i) |=> ($stable(cyc_cnt_o) && $stable(ret_cnt_o) && $stable(prog_cnt_o)));

    // R6
    cyc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == '0) |=> cyc_cnt_o == $past(wr_data_i));

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|irq_en_i));

    // R9
    flip_keeps_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_i && !$past(dbg_i) && cnt_en_o != $past(cnt_en_o)) |-> clk_en_o);

    // R9
    write_keeps_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> clk_en_o);
endmodule

bind evt_ctr_bank evb_chk #(.CNT_W(CNT_W), .N_PROG(N_PROG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_i      (dbg_i),
    .inh_i      (inh_i),
    .irq_en_i   (irq_en_i),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .cyc_cnt_o  (cyc_cnt_o),
    .ret_cnt_o  (ret_cnt_o),
    .prog_cnt_o (prog_cnt_o),
    .cnt_en_o   (cnt_en_o),
    .clk_en_o   (clk_en_o),
    .irq_o      (irq_o)
);

// File: tb/tb_evt_ctr_bank.sv
`timescale 1ns/1ps
module tb_evt_ctr_bank;
    localparam int CNT_W  = 64;
    localparam int N_PROG = 4;
    localparam int SEL_W  = 8;
    localparam int NSLOT  = N_PROG + 3;
    localparam int SLOT_W = $clog2(NSLOT);

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] mode;
    logic dis_m, dis_s, dis_u, dbg, ret, wr_en;
    logic [NSLOT-1:0] inh;
    logic [N_PROG-1:0] mask, evt, irq_en;
    logic [N_PROG*SEL_W-1:0] sel;
    logic [SLOT_W-1:0] wr_idx;
    logic [CNT_W-1:0] wr_data;
    logic [CNT_W-1:0] cyc_cnt, ret_cnt;
    logic [N_PROG*CNT_W-1:0] prog_cnt;
    logic cnt_en, clk_en, irq;

    always #4 clk = ~clk;

    evt_ctr_bank #(.CNT_W(CNT_W), .N_PROG(N_PROG), .SEL_W(SEL_W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dis_m_i(dis_m), .dis_s_i(dis_s),
        .dis_u_i(dis_u), .dbg_i(dbg), .inh_i(inh), .mask_i(mask), .sel_i(sel),
        .ret_i(ret), .evt_i(evt), .irq_en_i(irq_en), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_data_i(wr_data), .cyc_cnt_o(cyc_cnt),
        .ret_cnt_o(ret_cnt), .prog_cnt_o(prog_cnt), .cnt_en_o(cnt_en),
        .clk_en_o(clk_en), .irq_o(irq)
    );

    logic [CNT_W-1:0] m_cnt [NSLOT];
    logic [N_PROG-1:0] m_ovf;
    logic m_prev_dis;
    int errs = 0;
    int checks = 0;
    bit finished = 0;

    function automatic logic f_dis(logic [1:0] m, logic dm, logic ds, logic du);
        case (m)
            2'b11:   return dm;
            2'b01:   return ds;
            2'b00:   return du;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk64(string tag, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk64({tag, " R3 cycle"}, cyc_cnt, m_cnt[0]);
        chk64({tag, " R4 retired"}, ret_cnt, m_cnt[2]);
        for (int k = 0; k < N_PROG; k++)
            chk64({tag, " R5 prog"}, prog_cnt[k*CNT_W +: CNT_W], m_cnt[3+k]);
        chk1({tag, " R7 irq"}, irq, |(m_ovf & irq_en));
    endtask

    // Applies the inputs currently driven for one clock and checks the results.
    task automatic run_cycle(string tag);
        logic d, base, arm_any, ce;
        logic [CNT_W-1:0] old;
        #1;
        d    = f_dis(mode, dis_m, dis_s, dis_u);
        base = !dbg && !d;
        arm_any = (base && !inh[0]) || (base && !inh[2]);
        for (int k = 0; k < N_PROG; k++)
            arm_any |= base && !mask[k] && !inh[3+k] && (sel[k*SEL_W +: SEL_W] != 0);
        ce = arm_any || wr_en || (d != m_prev_dis);
        chk1({tag, " R8 cnt_en"}, cnt_en, base);
        chk1({tag, " R9 clk_en"}, clk_en, ce);
        // model update
        if (wr_en && wr_idx == 0) m_cnt[0] = wr_data;
        else if (base && !inh[0]) m_cnt[0] = m_cnt[0] + 1;
        if (wr_en && wr_idx == 2) m_cnt[2] = wr_data;
        else if (base && !inh[2] && ret) m_cnt[2] = m_cnt[2] + 1;
        for (int k = 0; k < N_PROG; k++) begin
            if (wr_en && int'(wr_idx) == 3 + k) begin
                m_cnt[3+k] = wr_data;
                m_ovf[k] = 1'b0;
            end else if (base && !mask[k] && !inh[3+k] && (sel[k*SEL_W +: SEL_W] != 0) && evt[k]) begin
                old = m_cnt[3+k];
                m_cnt[3+k] = old + 1;
                if (&old) m_ovf[k] = 1'b1;
            end
        end
        m_prev_dis = d;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic quiet_inputs();
        mode = 2'b11; dis_m = 0; dis_s = 0; dis_u = 0; dbg = 0;
        inh = '0; mask = '0; evt = '0; irq_en = '0; ret = 0;
        sel = {N_PROG{8'h01}}; wr_en = 0; wr_idx = '0; wr_data = '0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] snap;
        int tally_ok;
        int seed_v;
        seed_v = $urandom(32'd20240611);
        quiet_inputs();
        for (int s = 0; s < NSLOT; s++) m_cnt[s] = '0;
        m_ovf = '0;
        m_prev_dis = 1'b0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        compare_all("R10 reset");

        // R2 transition: user disabled, events every cycle
        dis_u = 1; ret = 1; evt = '1;
        run_cycle("R2 machine");
        mode = 2'b00;
        snap = cyc_cnt;
        run_cycle("R2 enter user");
        chk64("R2 no count on entry", cyc_cnt, snap);
        mode = 2'b11;
        run_cycle("R2 leave user");
        chk64("R2 count on exit", cyc_cnt, snap + 1);

        // R1 reserved mode code is disabled
        dis_u = 0; mode = 2'b10;
        snap = ret_cnt;
        run_cycle("R1 reserved");
        chk64("R1 reserved no count", ret_cnt, snap);
        mode = 2'b01; dis_s = 1;
        run_cycle("R1 supervisor disabled");
        chk64("R1 supervisor no count", ret_cnt, snap);
        dis_s = 0; mode = 2'b11;

        // R5 zero selector, mask, inhibit
        sel[0 +: SEL_W] = '0; mask[1] = 1; inh[5] = 1;
        run_cycle("R5 gating");
        sel = {N_PROG{8'h01}}; mask = '0; inh = '0;

        // R6 write priority and ignored slots
        wr_en = 1; wr_idx = 0; wr_data = 64'h1234;
        run_cycle("R6 cycle preset");
        chk64("R6 preset wins", cyc_cnt, 64'h1234);
        wr_idx = 1; wr_data = 64'hdead;
        run_cycle("R6 slot1 ignored");
        wr_idx = 7;
        run_cycle("R6 slot7 ignored");

        // R7 overflow
        wr_idx = 3; wr_data = '1; irq_en = 4'b0001;
        run_cycle("R7 preset max");
        wr_en = 0; evt = 4'b0001;
        run_cycle("R7 wrap");
        chk1("R7 irq after wrap", irq, 1'b1);
        chk64("R7 wrapped to zero", prog_cnt[0 +: CNT_W], '0);
        irq_en = 4'b0000;
        run_cycle("R7 irq masked");
        irq_en = 4'b0001; wr_en = 1; wr_data = 64'h5;
        run_cycle("R7 write clears flag");
        chk1("R7 irq cleared", irq, 1'b0);
        wr_en = 0;

        // R2 accounting: toggling modes, events every cycle
        dis_s = 1; dis_m = 0; dis_u = 0; ret = 1;
        snap = ret_cnt;
        tally_ok = 0;
        for (int i = 0; i < 400; i++) begin
            mode = ($urandom % 3 == 0) ? 2'b11 : (($urandom % 2) ? 2'b01 : 2'b00);
            if (mode != 2'b01) tally_ok++;
            run_cycle("R2 toggle");
        end
        chk64("R2 per-mode accounting", ret_cnt - snap, CNT_W'(tally_ok));

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            mode    = 2'($urandom);
            dis_m   = ($urandom % 4 == 0);
            dis_s   = ($urandom % 3 == 0);
            dis_u   = ($urandom % 3 == 0);
            dbg     = ($urandom % 8 == 0);
            inh     = ($urandom % 4 == 0) ? NSLOT'($urandom) : '0;
            mask    = ($urandom % 4 == 0) ? N_PROG'($urandom) : '0;
            for (int k = 0; k < N_PROG; k++)
                sel[k*SEL_W +: SEL_W] = ($urandom % 4 == 0) ? '0 : SEL_W'($urandom);
            ret     = $urandom % 2;
            evt     = N_PROG'($urandom);
            irq_en  = N_PROG'($urandom);
            wr_en   = ($urandom % 32 == 0);
            wr_idx  = SLOT_W'($urandom);
            wr_data = ($urandom % 2) ? ({CNT_W{1'b1}} - CNT_W'($urandom % 4)) : {$urandom, $urandom};
            run_cycle("R3 R4 R5 R6 R7 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule